// File: doc/BRIEF.md
# Sector Erase Collection Window

This block sits between a flash command decoder and the erase engine. When the decoder sees a sector erase command it strobes the block with the sector number. The block records that sector in a bitmap and opens a timed acceptance window. Every further sector command that arrives before the window runs out adds its sector to the bitmap and restarts the window at its full length. When the window finally runs out, the block raises its window-closed status bit, pulses an erase-start strobe for one cycle, and hands the bitmap to the erase engine.

While the erase runs, the block tells the decoder to drop every command except erase suspend. It holds the bitmap until the erase engine reports completion. A chip erase command skips the window entirely: it selects every sector and starts at once. Any command other than a sector erase or a suspend that arrives while the window is open cancels the collection and discards the gathered sectors. The window length is a parameter counted in clock cycles.

Top module: `sew_window`

## Requirements
- R1: After reset, window_shut_o, cmd_lock_o and erase_go_o are 0 and sector_map_o is all zeros.
- R2: A sector strobe taken while idle sets bit sect_idx_i of sector_map_o on the next cycle. window_shut_o and cmd_lock_o stay 0.
- R3: When no further sector strobe arrives, erase_go_o and window_shut_o rise exactly WINDOW_CYCLES clock edges after the edge that took the last sector strobe, and not one edge earlier.
- R4: A sector strobe taken while the window is open adds its bit to sector_map_o and restarts the full WINDOW_CYCLES window. This includes a strobe taken exactly WINDOW_CYCLES edges after the previous one.
- R5: erase_go_o is high for exactly one cycle per erase start.
- R6: While window_shut_o is 1, the sector, chip and other-command strobes have no effect: sector_map_o is held and window_shut_o stays 1. cmd_lock_o is 1 except in a cycle in which susp_cmd_i is high, where it is 0.
- R7: An erase_done_i taken while window_shut_o is 1 returns the block to idle on the next cycle. window_shut_o and cmd_lock_o go to 0 and sector_map_o is cleared.
- R8: A chip strobe taken while idle makes the next cycle show window_shut_o=1, cmd_lock_o=1, erase_go_o=1 and sector_map_o all ones, with no window. It takes precedence over a simultaneous sector strobe.
- R9: An other-command or chip strobe taken while the window is open clears sector_map_o, returns to idle and produces no erase start. It takes precedence over a simultaneous sector strobe.
- R10: A suspend strobe has no effect while idle or while the window is open. The window keeps its original expiry.
- R11: erase_done_i has no effect unless window_shut_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sect_cmd_i | input | 1 | Sector erase command strobe |
| sect_idx_i | input | SECT_W | Sector number that goes with sect_cmd_i |
| chip_cmd_i | input | 1 | Chip erase command strobe |
| susp_cmd_i | input | 1 | Erase suspend command strobe |
| other_cmd_i | input | 1 | Strobe for any other command |
| erase_done_i | input | 1 | Erase engine finished |
| window_shut_o | output | 1 | Status bit: 0 while sectors can still be added, 1 once the erase has begun |
| sector_map_o | output | NUM_SECTORS | Bitmap of the selected sectors |
| erase_go_o | output | 1 | One-cycle erase start pulse |
| cmd_lock_o | output | 1 | Tells the decoder to drop the current command |

## Verification
Every registered result is due on the clock edge that samples the strobe. The exceptions are the erase start, which is due WINDOW_CYCLES edges after the last accepted sector strobe, and cmd_lock_o, which follows susp_cmd_i in the same cycle. The driver knows which edge will sample each strobe, so it queues the expected outputs against that edge number. A monitor compares the outputs one time unit after each rising edge and checks the queue entry for that edge. Checks one edge before each expected expiry catch an erase that starts too early. Checks at the original expiry after a cancel catch a window that keeps running.

// File: rtl/sew_pkg.sv
package sew_pkg;

    typedef enum logic [1:0] {
        SEW_IDLE    = 2'd0,
        SEW_COLLECT = 2'd1,
        SEW_ERASE   = 2'd2
    } sew_state_e;

    typedef struct packed {
        sew_state_e state;
        logic       go;
    } sew_ctrl_t;

endpackage

// File: rtl/sew_timer.sv
module sew_timer #(
    parameter int WINDOW_CYCLES = 20,
    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.count = CNT_W'(WINDOW_CYCLES);
        end else if (!run_i) begin
            tmr_d.count = '0;
        end else if (tmr_q.count != '0) begin
            tmr_d.count = tmr_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last_o = (tmr_q.count == CNT_W'(1));

endmodule

// File: rtl/sew_bitmap.sv
module sew_bitmap #(
    parameter int NUM_SECTORS = 16,
    localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   fill_i,
    input  logic                   set_i,
    input  logic [SECT_W-1:0]      idx_i,
    output logic [NUM_SECTORS-1:0] map_o
);

    logic [NUM_SECTORS-1:0] map_d, map_q;

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
        always_comb begin
            map_d[i] = map_q[i];
            if (clr_i) begin
                map_d[i] = 1'b0;
            end else if (fill_i) begin
                map_d[i] = 1'b1;
            end else if (set_i && (idx_i == SECT_W'(i))) begin
                map_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign map_o = map_q;

endmodule

// File: rtl/sew_window.sv
module sew_window
    import sew_pkg::*;
#(
    parameter int NUM_SECTORS   = 16,
    parameter int WINDOW_CYCLES = 20,
    localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sect_cmd_i,
    input  logic [SECT_W-1:0]      sect_idx_i,
    input  logic                   chip_cmd_i,
    input  logic                   susp_cmd_i,
    input  logic                   other_cmd_i,
    input  logic                   erase_done_i,
    output logic                   window_shut_o,
    output logic [NUM_SECTORS-1:0] sector_map_o,
    output logic                   erase_go_o,
    output logic                   cmd_lock_o
);

    sew_ctrl_t ctrl_d, ctrl_q;

    logic tmr_load;
    logic tmr_last;
    logic map_clr;
    logic map_fill;
    logic map_set;
    logic abort_cmd;

    assign abort_cmd = other_cmd_i | chip_cmd_i;

    always_comb begin
        ctrl_d    = ctrl_q;
        ctrl_d.go = 1'b0;
        tmr_load  = 1'b0;
        map_clr   = 1'b0;
        map_fill  = 1'b0;
        map_set   = 1'b0;
        unique case (ctrl_q.state)
            SEW_IDLE: begin
                if (chip_cmd_i) begin
                    ctrl_d.state = SEW_ERASE;
                    ctrl_d.go    = 1'b1;
                    map_fill     = 1'b1;
                end else if (sect_cmd_i) begin
                    ctrl_d.state = SEW_COLLECT;
                    tmr_load     = 1'b1;
                    map_set      = 1'b1;
                end
            end
            SEW_COLLECT: begin
                if (abort_cmd) begin
                    ctrl_d.state = SEW_IDLE;
                    map_clr      = 1'b1;
                end else if (sect_cmd_i) begin
                    tmr_load     = 1'b1;
                    map_set      = 1'b1;
                end else if (tmr_last) begin
                    ctrl_d.state = SEW_ERASE;
                    ctrl_d.go    = 1'b1;
                end
            end
            SEW_ERASE: begin
                if (erase_done_i) begin
                    ctrl_d.state = SEW_IDLE;
                    map_clr      = 1'b1;
                end
            end
            default: begin
                ctrl_d.state = SEW_IDLE;
                map_clr      = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.state <= SEW_IDLE;
            ctrl_q.go    <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    sew_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (ctrl_q.state == SEW_COLLECT),
        .last_o (tmr_last)
    );

    sew_bitmap #(
        .NUM_SECTORS(NUM_SECTORS)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (map_clr),
        .fill_i (map_fill),
        .set_i  (map_set),
        .idx_i  (sect_idx_i),
        .map_o  (sector_map_o)
    );

    assign window_shut_o = (ctrl_q.state == SEW_ERASE);
    assign erase_go_o    = ctrl_q.go;
    assign cmd_lock_o    = window_shut_o & ~susp_cmd_i;

endmodule

// File: rtl/sew_window_chk.sv
module sew_window_chk #(
    parameter int NUM_SECTORS = 16,
    localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sect_cmd_i,
    input logic [SECT_W-1:0]      sect_idx_i,
    input logic                   chip_cmd_i,
    input logic                   susp_cmd_i,
    input logic                   other_cmd_i,
    input logic                   erase_done_i,
    input logic                   window_shut_o,
    input logic [NUM_SECTORS-1:0] sector_map_o,
    input logic                   erase_go_o,
    input logic                   cmd_lock_o
);

    a_r5_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go_o |=> !erase_go_o);

    a_r3_shut_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_shut_o) |-> erase_go_o);

    a_r6_map_held: assert property (@(posedge clk) disable iff (!rst_n)
        (window_shut_o && !erase_done_i) |=> (window_shut_o && $stable(sector_map_o)));

    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (window_shut_o && erase_done_i) |=> (!window_shut_o && sector_map_o == '0));

    a_r6_lock_needs_sectors: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lock_o |-> (sector_map_o != '0 && !susp_cmd_i));

    a_r11_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_shut_o && erase_done_i && !sect_cmd_i && !chip_cmd_i && !other_cmd_i)
        |=> $stable(sector_map_o));

endmodule

bind sew_window sew_window_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (.*);

// File: tb/sim_sew_window.sv
module sim_sew_window;

    localparam int NS = 16;
    localparam int W  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sect_cmd = 1'b0;
    logic [3:0]    sect_idx = '0;
    logic          chip_cmd = 1'b0;
    logic          susp_cmd = 1'b0;
    logic          other_cmd = 1'b0;
    logic          erase_done = 1'b0;
    logic          shut;
    logic [NS-1:0] map;
    logic          go;
    logic          lock;

    int cyc = 0;
    int checks = 0;
    int failures = 0;

    typedef struct {
        int            due;
        logic          go;
        logic          st;
        logic          lk;
        logic [NS-1:0] map;
        string         req;
    } exp_t;

    exp_t q[$];

    sew_window #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .sect_cmd_i    (sect_cmd),
        .sect_idx_i    (sect_idx),
        .chip_cmd_i    (chip_cmd),
        .susp_cmd_i    (susp_cmd),
        .other_cmd_i   (other_cmd),
        .erase_done_i  (erase_done),
        .window_shut_o (shut),
        .sector_map_o  (map),
        .erase_go_o    (go),
        .cmd_lock_o    (lock)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int due, input logic g, input logic s, input logic l,
                             input logic [NS-1:0] m, input string req);
        exp_t e;
        e.due = due; e.go = g; e.st = s; e.lk = l; e.map = m; e.req = req;
        q.push_back(e);
    endtask

    // monitor: compares one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (go !== e.go || shut !== e.st || lock !== e.lk || map !== e.map) begin
                    failures++;
                    $display("FAIL %s edge=%0d actual go=%b shut=%b lock=%b map=%h expected go=%b shut=%b lock=%b map=%h",
                             e.req, cyc, go, shut, lock, map, e.go, e.st, e.lk, e.map);
                end
            end
        end
    end

    // driver: called at a falling edge; se is the edge that samples the strobes
    task automatic drv(input logic s, input int idx, input logic c, input logic sp,
                       input logic o, input logic d, output int se);
        sect_cmd = s; sect_idx = 4'(idx); chip_cmd = c;
        susp_cmd = sp; other_cmd = o; erase_done = d;
        se = cyc + 1;
    endtask

    task automatic tick();
        @(negedge clk);
        sect_cmd = 1'b0; chip_cmd = 1'b0; susp_cmd = 1'b0;
        other_cmd = 1'b0; erase_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired at edge %0d", cyc);
        summary();
    end

    initial begin
        int se, se2, se3;
        idle(3);
        rst_n = 1'b1;
        expect_at(cyc + 1, 0, 0, 0, '0, "R1");
        idle(2);

        // single sector, window expiry, erase, strobes ignored, done
        drv(1, 3, 0, 0, 0, 0, se);
        expect_at(se,         0, 0, 0, 16'h0008, "R2");
        expect_at(se + W - 1, 0, 0, 0, 16'h0008, "R3");
        expect_at(se + W,     1, 1, 1, 16'h0008, "R3");
        expect_at(se + W + 1, 0, 1, 1, 16'h0008, "R5");
        tick(); idle(W + 2);
        drv(1, 5, 1, 0, 1, 0, se);
        expect_at(se, 0, 1, 1, 16'h0008, "R6");
        tick(); idle(2);
        drv(0, 0, 0, 1, 0, 0, se);
        expect_at(se,     0, 1, 0, 16'h0008, "R6");
        expect_at(se + 1, 0, 1, 1, 16'h0008, "R6");
        tick(); idle(1);
        drv(0, 0, 0, 0, 0, 1, se);
        expect_at(se, 0, 0, 0, '0, "R7");
        tick(); idle(2);

        // done and suspend while idle
        drv(0, 0, 0, 0, 0, 1, se);
        expect_at(se, 0, 0, 0, '0, "R11");
        tick();
        drv(0, 0, 0, 1, 0, 0, se);
        expect_at(se, 0, 0, 0, '0, "R10");
        tick(); idle(2);

        // accumulation at the boundary spacing, suspend and done inside the window
        drv(1, 1, 0, 0, 0, 0, se);
        expect_at(se, 0, 0, 0, 16'h0002, "R2");
        tick(); idle(W - 1);
        drv(1, 9, 0, 0, 0, 0, se2);
        expect_at(se2, 0, 0, 0, 16'h0202, "R4");
        tick(); idle(4);
        drv(0, 0, 0, 1, 0, 1, se3);
        expect_at(se3,         0, 0, 0, 16'h0202, "R10/R11");
        expect_at(se2 + W - 1, 0, 0, 0, 16'h0202, "R4");
        expect_at(se2 + W,     1, 1, 1, 16'h0202, "R4");
        tick(); idle(W);
        drv(0, 0, 0, 0, 0, 1, se);
        expect_at(se, 0, 0, 0, '0, "R7");
        tick(); idle(2);

        // other command inside the window, with a simultaneous sector strobe
        drv(1, 2, 0, 0, 0, 0, se);
        tick(); idle(3);
        drv(1, 4, 0, 0, 1, 0, se2);
        expect_at(se2,     0, 0, 0, '0, "R9");
        expect_at(se + W,  0, 0, 0, '0, "R9");
        expect_at(se2 + W, 0, 0, 0, '0, "R9");
        tick(); idle(W + 1);

        // chip strobe inside the window cancels
        drv(1, 6, 0, 0, 0, 0, se);
        tick(); idle(2);
        drv(0, 0, 1, 0, 0, 0, se2);
        expect_at(se2,     0, 0, 0, '0, "R9");
        expect_at(se2 + W, 0, 0, 0, '0, "R9");
        tick(); idle(W + 1);

        // chip erase from idle beats a sector strobe
        drv(1, 7, 1, 0, 0, 0, se);
        expect_at(se,     1, 1, 1, {NS{1'b1}}, "R8");
        expect_at(se + 1, 0, 1, 1, {NS{1'b1}}, "R5");
        tick(); idle(3);
        drv(0, 0, 0, 0, 0, 1, se);
        expect_at(se, 0, 0, 0, '0, "R7");
        tick(); idle(W + 5);

        if (q.size() != 0) begin
            failures++;
            $display("FAIL R3 unchecked expectations actual=%0d expected=0", q.size());
        end
        summary();
    end

endmodule